// File: doc/BRIEF.md
# Timer Channel Pin Capture and GPIO Unit

This block owns the single external pin of one general-purpose timer channel. A 32-bit mode register chooses the pin's job. The pin can be a plain GPIO input. It can be a GPIO output, driven either push-pull or open-drain. It can also be an edge-detecting interrupt source. The pin input is brought into the clock domain by a synchroniser. Its live level can be read in the status register.

When capture is configured, the block compares the current synchronised level with the level one clock earlier. An edge of the selected polarity sets a sticky event flag. Software clears the flag by writing a one to it. The flags, gated by an interrupt enable bit, drive a single interrupt output. Counting, PWM and compare waveform generation are not part of this block. The pin-function codes for those modes are stored, but they do not drive the pin.

The register port is a one-word-wide read/write port. A one-bit address selects between two registers: address 0 is the mode register and address 1 is the status register. Reads are combinational. Writes take effect at the clock edge on which `wr_i` is high.

Top module: `tpc_pin_unit`

## Requirements
- R1: After reset, the mode register reads 0, the status flags read 0, `irq_o` is 0 and `pin_oe_o` is 0.
- R2: The mode register (address 0) stores only these bits: [2:0] pin function, [5:4] GPIO control, 8 interrupt enable, 9 open-drain, and [17:16] edge select. The writable mask is 0x0003_0337. All other bits read 0, and writes to them are ignored.
- R3: Status bit 8 (address 1) shows the pin level delayed by SYNC_STAGES clocks (2 by default). Status bits other than 8 and [3:0] read 0.
- R4: Edge select 01 captures rising edges, 10 captures falling edges, 11 captures both, and 00 captures none. A captured edge sets status flag 0 one clock after the synchronised level changes, which is the third clock edge after the pin changes.
- R5: While the pin function field [2:0] is 0 (channel off), edges never set a flag.
- R6: Flags are sticky. Writing 1 to a status bit in [3:0] clears that flag, and writing 0 leaves it unchanged. Flags [3:1] have no source and always read 0.
- R7: If a new edge and a clear of the same flag fall on the same clock, the flag stays set.
- R8: `irq_o` is 1 exactly when some flag is set and mode bit 8 is 1.
- R9: The pin is driven only when the function field is 4 (GPIO) and GPIO control is 10 (drive low) or 11 (drive high). GPIO control 00 or 01, and any other function code, leave `pin_oe_o` at 0. When the pin is driven, `pin_o` equals GPIO control bit 4.
- R10: With mode bit 9 set, a low output value drives the pin low, and a high output value releases the pin (`pin_oe_o` = 0).
- R11: Any nonzero edge select forces `pin_oe_o` to 0, whatever the GPIO control bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 mode, 1 status |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| pin_i | input | 1 | Pin level from the pad |
| pin_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- The interrupt output agrees with the flags and the enable bit.
- An open-drain pin is never actively driven high.
- Capture mode never drives the pin.
- The reserved mode bits stay zero.
- Flag 0 stays set until a write clears it.
- Flag 0 is only ever raised while the channel is on.

Some behaviour only the bench scenarios can show. These are the exact latency from a pin change to the level bit and then to the flag, the selection of rising, falling or both edges, the set-over-clear collision, and the full drive truth table across every function code, GPIO control value, open-drain setting and edge select.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned FLAG_W    = 4;
  localparam int unsigned LEVEL_BIT = 8;
  localparam logic [REG_W-1:0] MODE_MASK = 32'h0003_0337;

  typedef enum logic [2:0] {
    FN_OFF     = 3'd0,
    FN_CAPTURE = 3'd1,
    FN_COMPARE = 3'd2,
    FN_PWM     = 3'd3,
    FN_GPIO    = 3'd4
  } pin_fn_e;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       open_drain;
    logic       irq_en;
    logic       gpio_drive;
    logic       gpio_val;
    pin_fn_e    fn;
  } mode_t;

  function automatic mode_t decode_mode(input logic [REG_W-1:0] w);
    mode_t m;
    m.fn         = pin_fn_e'(w[2:0]);
    m.gpio_val   = w[4];
    m.gpio_drive = w[5];
    m.irq_en     = w[8];
    m.open_drain = w[9];
    m.edge_sel   = w[17:16];
    return m;
  endfunction
endpackage

// File: rtl/tpc_pin_sync.sv
module tpc_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  generate
    for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  // last stage holds the previous synchronised level
  assign level_o = chain_q[SYNC_STAGES-1];
  assign rise_o  =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign fall_o  = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
endmodule

// File: rtl/tpc_event_flags.sv
module tpc_event_flags #(
  parameter int unsigned NUM_FLAGS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)       flags_o[i] <= 1'b0;
        else if (set_i[i]) flags_o[i] <= 1'b1;  // set wins over clear
        else if (clr_i[i]) flags_o[i] <= 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tpc_pin_drive.sv
module tpc_pin_drive
  import tpc_pkg::*;
(
  input  mode_t mode_i,
  output logic  pin_o,
  output logic  pin_oe_o
);
  logic drive_en;

  // capture use makes the pin input-only
  assign drive_en = (mode_i.fn == FN_GPIO) && mode_i.gpio_drive &&
                    (mode_i.edge_sel == 2'b00);
  assign pin_o    = mode_i.open_drain ? 1'b0 : mode_i.gpio_val;
  assign pin_oe_o = drive_en && !(mode_i.open_drain && mode_i.gpio_val);
endmodule

// File: rtl/tpc_pin_unit.sv
module tpc_pin_unit
  import tpc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             irq_o
);
  logic [REG_W-1:0]  mode_q;
  mode_t             mode;
  logic              level, rise, fall, hit;
  logic [FLAG_W-1:0] flags, flag_set, flag_clr;
  logic [REG_W-1:0]  status_word;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                mode_q <= '0;
    else if (wr_i && !addr_i)   mode_q <= wdata_i & MODE_MASK;

  assign mode = decode_mode(mode_q);

  tpc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign hit = (mode.fn != FN_OFF) &&
               ((mode.edge_sel[0] && rise) || (mode.edge_sel[1] && fall));

  assign flag_set = {{(FLAG_W-1){1'b0}}, hit};
  assign flag_clr = (wr_i && addr_i) ? wdata_i[FLAG_W-1:0] : '0;

  tpc_event_flags #(.NUM_FLAGS(FLAG_W)) flags_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );

  tpc_pin_drive drive_i (
    .mode_i   (mode),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  always_comb begin
    status_word              = '0;
    status_word[FLAG_W-1:0]  = flags;
    status_word[LEVEL_BIT]   = level;
  end

  assign rdata_o = addr_i ? status_word : mode_q;
  assign irq_o   = (|flags) && mode.irq_en;
endmodule

// File: rtl/tpc_pin_unit_chk.sv
module tpc_pin_unit_chk
  import tpc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             addr_i,
  input logic             wr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] mode_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic             irq_o
);
  AST_IRQ_WHEN_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|flags_i) && mode_i[8]) |-> irq_o); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mode_i[8] && (|flags_i))); // R8
  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o && mode_i[9]) |-> !pin_o); // R10
  AST_CAPTURE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[17:16] != 2'b00) |-> !pin_oe_o); // R11
  AST_MODE_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i & ~MODE_MASK) == '0); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[0] && !(wr_i && addr_i && wdata_i[0])) |=> flags_i[0]); // R6
  AST_UPPER_FLAGS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i[FLAG_W-1:1] == '0); // R6
  AST_OFF_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[0]) |-> $past(mode_i[2:0] != 3'd0)); // R5
endmodule

bind tpc_pin_unit tpc_pin_unit_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .wdata_i  (wdata_i),
  .mode_i   (mode_q),
  .flags_i  (flags),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o)
);

// File: tb/tpc_pin_unit_tb_top.sv
`timescale 1ns/1ps
module tpc_pin_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pin = 1'b0;
  logic        pin_out, pin_oe, irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tpc_pin_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read_reg(input logic a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_reg(1'b0, v); check("R1 mode", v, 32'h0);
    read_reg(1'b1, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 oe", {31'b0, pin_oe}, 32'h0);

    // R2 mask
    write_reg(1'b0, 32'hFFFF_FFFF);
    read_reg(1'b0, v); check("R2 all ones", v, 32'h0003_0337);
    write_reg(1'b0, 32'hA5A5_A5A5);
    read_reg(1'b0, v); check("R2 pattern", v, 32'hA5A5_A5A5 & 32'h0003_0337);

    // R3 level latency
    write_reg(1'b0, 32'h0);
    @(negedge clk); pin = 1'b1;
    @(negedge clk); read_reg(1'b1, v); check("R3 level after 1 clk", v, 32'h0);
    @(negedge clk); read_reg(1'b1, v); check("R3 level after 2 clk", v, 32'h100);
    pin = 1'b0;
    repeat (4) @(negedge clk);
    read_reg(1'b1, v); check("R3 level low", v, 32'h0);

    // R4/R5 edge sweep over function and edge select
    for (int f = 0; f < 3; f++) begin
      for (int es = 0; es < 4; es++) begin
        logic [2:0] fn;
        bit on;
        fn = (f == 0) ? 3'd0 : (f == 1) ? 3'd1 : 3'd4;
        on = (fn != 3'd0) && (es != 0);
        write_reg(1'b0, {14'b0, es[1:0], 13'b0, fn});
        pin = 1'b0;
        repeat (4) @(negedge clk);
        write_reg(1'b1, 32'hF);
        pin = 1'b1;
        repeat (2) @(negedge clk);
        read_reg(1'b1, v); check("R4 flag not yet on rise", v, 32'h100);
        @(negedge clk);
        read_reg(1'b1, v);
        check(on ? "R4 rising capture" : "R5 off/none rising", v, 32'h100 | {31'b0, on && es[0]});
        write_reg(1'b1, 32'hF);
        pin = 1'b0;
        repeat (3) @(negedge clk);
        read_reg(1'b1, v);
        check(on ? "R4 falling capture" : "R5 off/none falling", v, {31'b0, on && es[1]});
      end
    end

    // R6 sticky, W1C, zero write keeps flag
    write_reg(1'b0, 32'h0001_0001);
    pin = 1'b1;
    repeat (4) @(negedge clk);
    pin = 1'b0;
    repeat (10) @(negedge clk);
    read_reg(1'b1, v); check("R6 sticky", v, 32'h1);
    write_reg(1'b1, 32'hFFFF_FFF0);
    read_reg(1'b1, v); check("R6 write zero keeps", v, 32'h1);

    // R8 irq gating
    check("R8 irq off without enable", {31'b0, irq}, 32'h0);
    write_reg(1'b0, 32'h0001_0101);
    check("R8 irq on", {31'b0, irq}, 32'h1);
    write_reg(1'b1, 32'h1);
    read_reg(1'b1, v); check("R6 w1c", v, 32'h0);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);

    // R7 set wins over same-cycle clear
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = 1'b1; wdata = 32'h1; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    read_reg(1'b1, v); check("R7 set beats clear", v, 32'h101);
    check("R8 irq from collision", {31'b0, irq}, 32'h1);
    write_reg(1'b1, 32'h1);
    pin = 1'b0;
    write_reg(1'b0, 32'h0);
    repeat (4) @(negedge clk);
    write_reg(1'b1, 32'hF);

    // R9/R10/R11 drive truth table
    for (int fn = 0; fn < 8; fn++)
      for (int g = 0; g < 4; g++)
        for (int od = 0; od < 2; od++)
          for (int es = 0; es < 4; es++) begin
            bit en, val, oe_exp;
            write_reg(1'b0, {14'b0, es[1:0], 6'b0, od[0], 3'b0, g[1:0], 1'b0, fn[2:0]});
            en = (fn == 4) && g[1] && (es == 0);
            val = g[0];
            oe_exp = en && !(od[0] && val);
            #1;
            check(es != 0 ? "R11 oe" : od[0] ? "R10 oe" : "R9 oe", {31'b0, pin_oe}, {31'b0, oe_exp});
            if (oe_exp) check("R9 pin value", {31'b0, pin_out}, {31'b0, val});
          end

    finish_run();
  end
endmodule